// File: doc/BRIEF.md
# Snoop Result Combiner with Duplicated Tags

This block produces the snoop response of a bus-based multiprocessor that runs an invalidation protocol with four line states (invalid, shared, exclusive, modified). It contains, for each cache, one snoop responder. The responder keeps two identical copies of the cache's tag-and-state store. The processor copy serves lookups and writes from the core. The bus copy serves snoops. Because of this split, a snoop never steals a cycle from the core.

When an address is accepted on the bus, every responder looks up the bus copy. Each responder then reports three things: whether it holds the block, whether it holds the block modified, and whether its lookup has finished. A combiner merges these reports into global shared, dirty and result-valid lines. It also raises a memory-inhibit signal, which tells memory to stay silent because a cache owns the data.

The result is valid a fixed number of cycles after the address. The requesting cache uses the global shared line to choose its fill state. The other caches downgrade or invalidate their copies. Every state change is written into both tag copies in the same cycle.

Top module: `snoop_combine_top`

## Requirements
- R1: After reset every line of every cache is invalid, and `snp_valid`, `snp_shared`, `snp_dirty` and `mem_inhibit` are low.
- R2: An address accepted in cycle c gives `snp_valid` high for exactly one cycle, cycle c+SNOOP_LAT (default 2). `snp_shared`, `snp_dirty` and `mem_inhibit` are low whenever `snp_valid` is low.
- R3: While `snp_valid` is high, `snp_shared` is high exactly when some cache other than the requester (`bus_src`) holds the addressed block in a valid state. A block is held when the stored tag equals address bits [7:3] and the state is not invalid.
- R4: While `snp_valid` is high, `snp_dirty` and `mem_inhibit` are high exactly when a cache other than the requester holds the block modified. At most one cache holds a given block modified.
- R5: State codes are I=0, S=1, E=2, M=3, and bus command codes are read=0, read-exclusive=1, upgrade=2; code 3 acts as code 2. At the end of the result cycle the requester installs the block. On a read it installs E when `snp_shared` is low and S when `snp_shared` is high. On a read-exclusive or an upgrade it installs M.
- R6: A non-requesting cache that hits on a read moves from E or M (or S) to S. A non-requesting cache that hits on a read-exclusive or an upgrade moves to I.
- R7: A processor write that hits E is granted and moves the line to M with no bus activity. A write that hits M is granted with no change. A write to a line in S, in I or with another tag is not granted and changes nothing.
- R8: Every state change is written into both tag copies. A silent E-to-M change is therefore reported as dirty by later snoops, and bus-driven changes are visible on `cpu_rd_state`.
- R9: While a transaction is in flight (from the cycle after acceptance through the result cycle), `bus_valid` is ignored.
- R10: A processor write whose set index (address bits [2:0]) equals the index of the in-flight transaction is not granted.
- R11: A block whose tag differs from the stored tag in the same set is a miss. On a fill it replaces the stored line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus address phase present |
| bus_cmd | input | 2 | Bus command code |
| bus_addr | input | ADDR_W | Block address: tag in upper bits, set index in lower IDX_W bits |
| bus_src | input | SRC_W | Index of the requesting cache |
| cpu_wr_valid | input | N_CACHE | Per-cache processor write request |
| cpu_wr_addr | input | N_CACHE*ADDR_W | Per-cache processor write address |
| cpu_rd_addr | input | N_CACHE*ADDR_W | Per-cache processor lookup address |
| cpu_wr_grant | output | N_CACHE | Per-cache write granted without bus action |
| cpu_rd_state | output | 2*N_CACHE | Per-cache looked-up state, I on a miss |
| snp_valid | output | 1 | Combined snoop result may be sampled |
| snp_shared | output | 1 | Another cache holds the block |
| snp_dirty | output | 1 | Another cache holds the block modified |
| mem_inhibit | output | 1 | Memory must not supply data |

## Verification
Some properties are checked by assertions on every cycle:
- the result-valid pulse is a single cycle and lands exactly SNOOP_LAT cycles after acceptance;
- dirty never appears without shared;
- no two caches report a modified copy at once;
- only one transaction is ever in flight;
- after any write the two tag copies agree at the written set.

The bench scenarios are what show the protocol outcomes. These are the E-versus-S fill choice, downgrade and invalidation in the snoopers, and a silent E-to-M write surfacing as dirty on a later snoop. The scenarios also show that a second address is dropped, that a write is refused while its set is being snooped, and that a tag conflict in one set is a miss that replaces the line.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  typedef enum logic [1:0] {
    CMD_RD   = 2'd0,
    CMD_RDX  = 2'd1,
    CMD_UPGR = 2'd2,
    CMD_RSV  = 2'd3
  } bcmd_e;

  // State the requester installs once the combined result is known.
  function automatic mesi_e fill_state(bcmd_e c, logic others_hold);
    if (c == CMD_RD) return others_hold ? ST_S : ST_E;
    return ST_M;
  endfunction

  // State a non-requesting cache moves to after it observes a command.
  function automatic mesi_e snoop_next(bcmd_e c, mesi_e s);
    if (s == ST_I)   return ST_I;
    if (c == CMD_RD) return ST_S;
    return ST_I;
  endfunction

  // A processor write completes locally only with exclusive ownership.
  function automatic logic wr_local_ok(mesi_e s);
    return (s == ST_E) || (s == ST_M);
  endfunction

endpackage

// File: rtl/snp_window.sv
module snp_window
  import snp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int SRC_W  = 2,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [1:0]        bus_cmd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SRC_W-1:0]  bus_src,
  output logic              accept,
  output logic              busy,
  output logic [IDX_W-1:0]  busy_idx,
  output logic [ADDR_W-1:0] look_addr,
  output logic              fin_v,
  output bcmd_e             fin_cmd,
  output logic [ADDR_W-1:0] fin_addr,
  output logic [SRC_W-1:0]  fin_src
);

  logic [LAT:1]      stv;
  logic [ADDR_W-1:0] sta [1:LAT];
  bcmd_e             stc [1:LAT];
  logic [SRC_W-1:0]  sts [1:LAT];

  assign busy   = |stv;
  assign accept = bus_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stv <= '0;
      for (int k = 1; k <= LAT; k++) begin
        sta[k] <= '0;
        stc[k] <= CMD_RD;
        sts[k] <= '0;
      end
    end else begin
      stv[1] <= accept;
      if (accept) begin
        sta[1] <= bus_addr;
        stc[1] <= bcmd_e'(bus_cmd);
        sts[1] <= bus_src;
      end
      for (int k = 2; k <= LAT; k++) begin
        stv[k] <= stv[k-1];
        sta[k] <= sta[k-1];
        stc[k] <= stc[k-1];
        sts[k] <= sts[k-1];
      end
    end
  end

  always_comb begin
    busy_idx = '0;
    for (int k = 1; k <= LAT; k++)
      if (stv[k]) busy_idx = sta[k][IDX_W-1:0];
  end

  assign look_addr = sta[1];
  assign fin_v     = stv[LAT];
  assign fin_cmd   = stc[LAT];
  assign fin_addr  = sta[LAT];
  assign fin_src   = sts[LAT];

  // R9
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stv));

endmodule

// File: rtl/snp_dual_tag.sv
module snp_dual_tag
  import snp_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] pr_idx,
  input  logic [IDX_W-1:0] pw_idx,
  input  logic [IDX_W-1:0] b_idx,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_wi,
  input  logic [TAG_W-1:0] bus_wt,
  input  mesi_e            bus_ws,
  input  logic             cpu_we,
  input  logic [IDX_W-1:0] cpu_wi,
  input  mesi_e            cpu_ws,
  output mesi_e            pr_st,
  output logic [TAG_W-1:0] pr_tag,
  output mesi_e            pw_st,
  output logic [TAG_W-1:0] pw_tag,
  output mesi_e            b_st,
  output logic [TAG_W-1:0] b_tag
);

  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0] p_tag [SETS];
  mesi_e            p_st  [SETS];
  logic [TAG_W-1:0] q_tag [SETS];
  mesi_e            q_st  [SETS];

  // Processor-side copy.
  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      if (!rst_n) begin
        p_tag[s] <= '0;
        p_st[s]  <= ST_I;
      end else if (bus_we && bus_wi == IDX_W'(s)) begin
        p_tag[s] <= bus_wt;
        p_st[s]  <= bus_ws;
      end else if (cpu_we && cpu_wi == IDX_W'(s)) begin
        p_st[s]  <= cpu_ws;
      end
    end
  end

  // Bus-side copy, written in the same cycle with the same data.
  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      if (!rst_n) begin
        q_tag[s] <= '0;
        q_st[s]  <= ST_I;
      end else if (bus_we && bus_wi == IDX_W'(s)) begin
        q_tag[s] <= bus_wt;
        q_st[s]  <= bus_ws;
      end else if (cpu_we && cpu_wi == IDX_W'(s)) begin
        q_st[s]  <= cpu_ws;
      end
    end
  end

  assign pr_st  = p_st[pr_idx];
  assign pr_tag = p_tag[pr_idx];
  assign pw_st  = p_st[pw_idx];
  assign pw_tag = p_tag[pw_idx];
  assign b_st   = q_st[b_idx];
  assign b_tag  = q_tag[b_idx];

  // R8
  copies_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we || cpu_we) |=>
      (p_st[$past(bus_we ? bus_wi : cpu_wi)] == q_st[$past(bus_we ? bus_wi : cpu_wi)]) &&
      (p_tag[$past(bus_we ? bus_wi : cpu_wi)] == q_tag[$past(bus_we ? bus_wi : cpu_wi)]));

endmodule

// File: rtl/snp_responder.sv
module snp_responder
  import snp_pkg::*;
#(
  parameter int ID     = 0,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3,
  parameter int SRC_W  = 2,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic              fin_v,
  input  bcmd_e             fin_cmd,
  input  logic [ADDR_W-1:0] fin_addr,
  input  logic [SRC_W-1:0]  fin_src,
  input  logic              busy,
  input  logic [IDX_W-1:0]  busy_idx,
  input  logic              glob_shared,
  input  logic              wr_v,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              done_o,
  output logic              hold_o,
  output logic              own_o,
  output logic              wr_grant,
  output logic [1:0]        rd_state
);

  localparam int TAG_W = ADDR_W - IDX_W;

  mesi_e            pr_st, pw_st, b_st;
  logic [TAG_W-1:0] pr_tag, pw_tag, b_tag;
  logic             bus_we, cpu_we;
  mesi_e            bus_ws;
  mesi_e            look_st;
  mesi_e            hs [2:LAT];
  logic             is_req, snoop_hit, wr_hit, wr_conflict;

  // Bus-side lookup in the first window stage.
  assign look_st = (b_st != ST_I && b_tag == look_addr[ADDR_W-1:IDX_W]) ? b_st : ST_I;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 2; k <= LAT; k++) hs[k] <= ST_I;
    end else begin
      hs[2] <= look_st;
      for (int k = 3; k <= LAT; k++) hs[k] <= hs[k-1];
    end
  end

  assign is_req    = fin_v && (fin_src == SRC_W'(ID));
  assign snoop_hit = fin_v && !is_req && (hs[LAT] != ST_I);

  assign done_o = fin_v;
  assign hold_o = snoop_hit;
  assign own_o  = snoop_hit && (hs[LAT] == ST_M);

  // Tag update at the end of the result cycle.
  assign bus_we = is_req || snoop_hit;
  assign bus_ws = is_req ? fill_state(fin_cmd, glob_shared) : snoop_next(fin_cmd, hs[LAT]);

  // Processor write port.
  assign wr_hit      = (pw_st != ST_I) && (pw_tag == wr_addr[ADDR_W-1:IDX_W]);
  assign wr_conflict = busy && (busy_idx == wr_addr[IDX_W-1:0]);
  assign wr_grant    = wr_v && wr_hit && wr_local_ok(pw_st) && !wr_conflict;
  assign cpu_we      = wr_grant && (pw_st == ST_E);

  assign rd_state = (pr_st != ST_I && pr_tag == rd_addr[ADDR_W-1:IDX_W]) ? pr_st : ST_I;

  snp_dual_tag #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .pr_idx (rd_addr[IDX_W-1:0]),
    .pw_idx (wr_addr[IDX_W-1:0]),
    .b_idx  (look_addr[IDX_W-1:0]),
    .bus_we (bus_we),
    .bus_wi (fin_addr[IDX_W-1:0]),
    .bus_wt (fin_addr[ADDR_W-1:IDX_W]),
    .bus_ws (bus_ws),
    .cpu_we (cpu_we),
    .cpu_wi (wr_addr[IDX_W-1:0]),
    .cpu_ws (ST_M),
    .pr_st  (pr_st),
    .pr_tag (pr_tag),
    .pw_st  (pw_st),
    .pw_tag (pw_tag),
    .b_st   (b_st),
    .b_tag  (b_tag)
  );

endmodule

// File: rtl/snp_combine.sv
module snp_combine #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] done_v,
  input  logic [N-1:0] hold_v,
  input  logic [N-1:0] own_v,
  output logic         snp_valid,
  output logic         snp_shared,
  output logic         snp_dirty,
  output logic         mem_inhibit
);

  // Result may be sampled only when no cache is still looking up.
  assign snp_valid   = &done_v;
  assign snp_shared  = snp_valid && (|hold_v);
  assign snp_dirty   = snp_valid && (|own_v);
  assign mem_inhibit = snp_valid && snp_dirty;

  // R3
  dirty_implies_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_dirty |-> snp_shared);

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !snp_valid);

endmodule

// File: rtl/snoop_combine_top.sv
module snoop_combine_top
  import snp_pkg::*;
#(
  parameter int  N_CACHE   = 4,
  parameter int  IDX_W     = 3,
  parameter int  TAG_W     = 5,
  parameter int  SNOOP_LAT = 2,
  localparam int ADDR_W    = TAG_W + IDX_W,
  localparam int SRC_W     = (N_CACHE > 1) ? $clog2(N_CACHE) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_valid,
  input  logic [1:0]                bus_cmd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [SRC_W-1:0]          bus_src,
  input  logic [N_CACHE-1:0]        cpu_wr_valid,
  input  logic [N_CACHE*ADDR_W-1:0] cpu_wr_addr,
  input  logic [N_CACHE*ADDR_W-1:0] cpu_rd_addr,
  output logic [N_CACHE-1:0]        cpu_wr_grant,
  output logic [2*N_CACHE-1:0]      cpu_rd_state,
  output logic                      snp_valid,
  output logic                      snp_shared,
  output logic                      snp_dirty,
  output logic                      mem_inhibit
);

  localparam int CW = $clog2(SNOOP_LAT + 2);

  logic              accept, busy;
  logic [IDX_W-1:0]  busy_idx;
  logic [ADDR_W-1:0] look_addr, fin_addr;
  logic              fin_v;
  bcmd_e             fin_cmd;
  logic [SRC_W-1:0]  fin_src;
  logic [N_CACHE-1:0] done_v, hold_v, own_v;
  logic [CW-1:0]     win_cnt;

  snp_window #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SRC_W(SRC_W), .LAT(SNOOP_LAT)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_cmd   (bus_cmd),
    .bus_addr  (bus_addr),
    .bus_src   (bus_src),
    .accept    (accept),
    .busy      (busy),
    .busy_idx  (busy_idx),
    .look_addr (look_addr),
    .fin_v     (fin_v),
    .fin_cmd   (fin_cmd),
    .fin_addr  (fin_addr),
    .fin_src   (fin_src)
  );

  for (genvar g = 0; g < N_CACHE; g++) begin : g_cache
    snp_responder #(
      .ID(g), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SRC_W(SRC_W), .LAT(SNOOP_LAT)
    ) u_resp (
      .clk         (clk),
      .rst_n       (rst_n),
      .look_addr   (look_addr),
      .fin_v       (fin_v),
      .fin_cmd     (fin_cmd),
      .fin_addr    (fin_addr),
      .fin_src     (fin_src),
      .busy        (busy),
      .busy_idx    (busy_idx),
      .glob_shared (snp_shared),
      .wr_v        (cpu_wr_valid[g]),
      .wr_addr     (cpu_wr_addr[g*ADDR_W +: ADDR_W]),
      .rd_addr     (cpu_rd_addr[g*ADDR_W +: ADDR_W]),
      .done_o      (done_v[g]),
      .hold_o      (hold_v[g]),
      .own_o       (own_v[g]),
      .wr_grant    (cpu_wr_grant[g]),
      .rd_state    (cpu_rd_state[2*g +: 2])
    );
  end

  snp_combine #(.N(N_CACHE)) u_comb (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_v      (done_v),
    .hold_v      (hold_v),
    .own_v       (own_v),
    .snp_valid   (snp_valid),
    .snp_shared  (snp_shared),
    .snp_dirty   (snp_dirty),
    .mem_inhibit (mem_inhibit)
  );

  // Cycles since the address was accepted, for the window check.
  always_ff @(posedge clk) begin
    if (!rst_n)      win_cnt <= '0;
    else if (accept) win_cnt <= CW'(1);
    else if (busy)   win_cnt <= win_cnt + CW'(1);
    else             win_cnt <= '0;
  end

  // R2
  snoop_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (win_cnt == CW'(SNOOP_LAT)));

  // R4
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_v));

endmodule

// File: tb/snoop_combine_top_bench.sv
module snoop_combine_top_bench;

  localparam int N  = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic [1:0]    bus_cmd = '0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    bus_src = '0;
  logic [N-1:0]  cpu_wr_valid = '0;
  logic [N*AW-1:0] cpu_wr_addr = '0;
  logic [N*AW-1:0] cpu_rd_addr = '0;
  logic [N-1:0]  cpu_wr_grant;
  logic [2*N-1:0] cpu_rd_state;
  logic snp_valid, snp_shared, snp_dirty, mem_inhibit;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  snoop_combine_top u_snoop_combine_top (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_src(bus_src), .cpu_wr_valid(cpu_wr_valid),
    .cpu_wr_addr(cpu_wr_addr), .cpu_rd_addr(cpu_rd_addr),
    .cpu_wr_grant(cpu_wr_grant), .cpu_rd_state(cpu_rd_state),
    .snp_valid(snp_valid), .snp_shared(snp_shared), .snp_dirty(snp_dirty),
    .mem_inhibit(mem_inhibit)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<20000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int id, input logic [7:0] a, output int st);
    cpu_rd_addr[id*AW +: AW] = a;
    #1;
    st = int'(cpu_rd_state[id*2 +: 2]);
  endtask

  // Bus transaction; state codes I=0 S=1 E=2 M=3, cmd RD=0 RDX=1 UPGR=2.
  task automatic bus_txn(input int src, input int cmd, input logic [7:0] a,
                         input int esh, input int edt, input int est);
    int st;
    @(negedge clk);
    bus_valid = 1'b1; bus_cmd = 2'(cmd); bus_addr = a; bus_src = 2'(src);
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R2 valid low one cycle after address", int'(snp_valid), 0);
    @(negedge clk);
    chk("R2 valid high at window", int'(snp_valid), 1);
    chk("R3 shared", int'(snp_shared), esh);
    chk("R4 dirty", int'(snp_dirty), edt);
    chk("R4 mem_inhibit", int'(mem_inhibit), edt);
    @(negedge clk);
    chk("R2 valid single pulse", int'(snp_valid), 0);
    rd(src, a, st);
    chk("R5 requester fill state", st, est);
  endtask

  task automatic cpu_wr(input int id, input logic [7:0] a, input int eg, input int est);
    int st;
    @(negedge clk);
    cpu_wr_valid[id] = 1'b1;
    cpu_wr_addr[id*AW +: AW] = a;
    #1;
    chk("R7 write grant", int'(cpu_wr_grant[id]), eg);
    @(negedge clk);
    cpu_wr_valid[id] = 1'b0;
    rd(id, a, st);
    chk("R7 state after write", st, est);
  endtask

  // {kind(0 bus,1 write), id, cmd, addr, exp_shared/grant, exp_dirty, exp_state}
  localparam logic [16:0] VEC [0:15] = '{
    {1'b0, 2'd0, 2'd0, 8'h09, 1'b0, 1'b0, 2'd2},  // first reader gets E
    {1'b0, 2'd1, 2'd0, 8'h09, 1'b1, 1'b0, 2'd1},  // second reader S
    {1'b1, 2'd0, 2'd0, 8'h09, 1'b0, 1'b0, 2'd1},  // write on S refused
    {1'b0, 2'd0, 2'd2, 8'h09, 1'b1, 1'b0, 2'd3},  // upgrade to M
    {1'b0, 2'd2, 2'd0, 8'h09, 1'b1, 1'b1, 2'd1},  // read hits M
    {1'b0, 2'd3, 2'd1, 8'h09, 1'b1, 1'b0, 2'd3},  // read-exclusive
    {1'b0, 2'd1, 2'd0, 8'h09, 1'b1, 1'b1, 2'd1},
    {1'b0, 2'd2, 2'd0, 8'h1A, 1'b0, 1'b0, 2'd2},
    {1'b1, 2'd2, 2'd0, 8'h1A, 1'b1, 1'b0, 2'd3},  // silent E to M
    {1'b0, 2'd0, 2'd0, 8'h1A, 1'b1, 1'b1, 2'd1},  // R8: silent M seen by bus copy
    {1'b0, 2'd1, 2'd0, 8'h11, 1'b0, 1'b0, 2'd2},  // R11: same set, other tag
    {1'b1, 2'd1, 2'd0, 8'h11, 1'b1, 1'b0, 2'd3},
    {1'b1, 2'd1, 2'd0, 8'h11, 1'b1, 1'b0, 2'd3},  // write on M granted
    {1'b0, 2'd3, 2'd0, 8'h11, 1'b1, 1'b1, 2'd1},
    {1'b0, 2'd0, 2'd1, 8'h1A, 1'b1, 1'b0, 2'd3},
    {1'b1, 2'd2, 2'd0, 8'h1A, 1'b0, 1'b0, 2'd0}   // write on I refused
  };

  initial begin
    int st;
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 snp_valid after reset", int'(snp_valid), 0);
    chk("R1 outputs after reset", int'({snp_shared, snp_dirty, mem_inhibit}), 0);
    for (int i = 0; i < N; i++) begin
      rd(i, 8'h09, st);
      chk("R1 line invalid after reset", st, 0);
    end

    for (int v = 0; v < 16; v++) begin
      if (VEC[v][16] == 1'b0)
        bus_txn(int'(VEC[v][15:14]), int'(VEC[v][13:12]), VEC[v][11:4],
                int'(VEC[v][3]), int'(VEC[v][2]), int'(VEC[v][1:0]));
      else
        cpu_wr(int'(VEC[v][15:14]), VEC[v][11:4], int'(VEC[v][3]), int'(VEC[v][1:0]));
    end

    // R6 snooper outcomes after the table
    rd(0, 8'h09, st); chk("R6 read-exclusive invalidated cache0", st, 0);
    rd(2, 8'h09, st); chk("R6 read-exclusive invalidated cache2", st, 0);
    rd(1, 8'h11, st); chk("R6 read moved M to S", st, 1);
    rd(3, 8'h11, st); chk("R11 fill replaced other tag", st, 1);
    rd(2, 8'h1A, st); chk("R6 read-exclusive invalidated S", st, 0);
    rd(0, 8'h1A, st); chk("R8 processor copy shows bus fill", st, 3);

    // R9: second address during window is ignored
    pulses = 0;
    @(negedge clk);
    bus_valid = 1'b1; bus_cmd = 2'd0; bus_addr = 8'h23; bus_src = 2'd0;
    @(negedge clk);
    bus_src = 2'd1;
    pulses += int'(snp_valid);
    @(negedge clk);
    bus_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      pulses += int'(snp_valid);
      @(negedge clk);
    end
    chk("R9 one result pulse", pulses, 1);
    rd(1, 8'h23, st); chk("R9 ignored requester stays invalid", st, 0);
    rd(0, 8'h23, st); chk("R9 accepted requester E", st, 2);

    // R10: write to the set being snooped is refused
    @(negedge clk);
    bus_valid = 1'b1; bus_cmd = 2'd0; bus_addr = 8'h2A; bus_src = 2'd1;
    @(negedge clk);
    bus_valid = 1'b0;
    cpu_wr_valid[0] = 1'b1;
    cpu_wr_addr[0 +: AW] = 8'h1A;
    #1;
    chk("R10 write in snooped set refused", int'(cpu_wr_grant[0]), 0);
    @(negedge clk);
    cpu_wr_valid[0] = 1'b0;
    repeat (2) @(negedge clk);
    rd(1, 8'h2A, st); chk("R11 miss against other tag fills E", st, 2);
    cpu_wr(0, 8'h1A, 1, 3); // R10 granted once the window has closed

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule